// File: doc/BRIEF.md
# Peripheral-Commanded Receive DMA Channel

This block is one memory-write DMA channel whose work unit is steered by the peripheral that feeds it. Each word the peripheral hands over comes with a two-bit command. Two of the codes ask for a data transfer: a normal one and an urgent one, sent when the peripheral's receive buffer has reached its high-water mark. The other two act on the work unit itself. Restart discards what the unit has received so far. Finish closes the unit early, which is how a frame of variable length ends when the count was loaded with a large ceiling.

Words are written through a simple memory write port. A current address counts up and a remaining count counts down. The channel holds one pending descriptor register (start address, count, interrupt enable), which the issuer refills through a push strobe. When a unit ends, the pending descriptor is taken at once if one is there. The number of words kept in the closed unit is latched on `done_words`. An `irq` pulse marks completion when the unit asked for one.

The controller has three states. S_IDLE has no work unit and waits for a descriptor. S_RUN accepts commands. S_END is a single completion cycle. The transitions are:
- IDLE_LOAD: S_IDLE to S_RUN, when a descriptor is pending.
- RUN_FINISH: S_RUN to S_END, on a finish command.
- RUN_EXHAUST: S_RUN to S_END, on the request that takes the last word of the count.
- END_CHAIN: S_END to S_RUN, when a descriptor is pending.
- END_STOP: S_END to S_IDLE, when no descriptor is pending.

Top module: `pcdma_rx_chan`

## Requirements
- R1: While reset is held and right after it, `cmd_ready`, `mem_we`, `urgent` and `irq` are low and `done_words` is zero.
- R2: A `desc_push` stores one pending descriptor, and a later push replaces one that has not yet been taken. If the push is sampled at clock edge k while the channel is in S_IDLE, the channel loads it at edge k+1 and `cmd_ready` is high after that edge.
- R3: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. An accepted code 2'b00 (normal request) or 2'b01 (urgent request) writes `cmd_data` to the current address, seen on `mem_we`/`mem_addr`/`mem_wdata` in the cycle after acceptance. The address then steps up by one and the remaining count steps down by one.
- R4: `urgent` is high, together with `mem_we`, exactly for the writes that came from code 2'b01.
- R5: An accepted code 2'b10 (restart) sets the current address and remaining count back to the unit's start values and clears the word tally, so the next write goes to the start address.
- R6: A restart neither ends the unit nor raises `irq`, and `cmd_ready` stays high.
- R7: An accepted code 2'b11 (finish) ends the unit whatever count remains. The channel spends one cycle in S_END. `irq` pulses for one cycle after that cycle if the unit's interrupt enable was set. A pending descriptor is loaded in S_END, so `cmd_ready` is high again after it.
- R8: On leaving S_END, `done_words` takes the number of words written since the unit's last load or restart.
- R9: When the request that takes the last word of the count is accepted, the unit completes as in R7. After that, `cmd_ready` stays low until a new descriptor is loaded.
- R10: Commands presented while `cmd_ready` is low cause no write and no change of state.
- R11: A unit loaded with its interrupt enable clear completes without an `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_push | input | 1 | Store the descriptor fields below as the pending descriptor |
| desc_addr | input | AW | Start address of the pushed descriptor |
| desc_count | input | CW | Word count of the pushed descriptor (nonzero) |
| desc_irq_en | input | 1 | Completion interrupt enable of the pushed descriptor |
| cmd_valid | input | 1 | Peripheral presents a command |
| cmd_code | input | 2 | 00 request, 01 urgent request, 10 restart, 11 finish |
| cmd_data | input | DW | Data word sent with request codes |
| cmd_ready | output | 1 | Channel is in S_RUN and takes commands |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| urgent | output | 1 | Current write has raised priority |
| irq | output | 1 | One-cycle completion interrupt |
| done_words | output | CW | Words kept in the last closed unit |

## Verification
The embedded assertions are checked on every cycle. They cover the following: a write always follows an accepted request, and urgency is only shown on a write. The interrupt never follows an accepted restart, and a finish always drops `cmd_ready` for the completion cycle. A pending descriptor is never taken when absent, a restart rewinds the address and tally, and the count never steps below zero. What only the bench's scenarios show is the following: the exact addresses and data written across restarts and chained units, the value latched in `done_words`, whether the pulse appears according to each unit's enable, and that commands offered while idle or after exhaustion leave no trace. A behavioural model, compared on every clock, covers these under a long randomized command mix with overlapping descriptor pushes.

// File: rtl/pcdma_pkg.sv
package pcdma_pkg;

    typedef enum logic [1:0] {
        CMD_REQ     = 2'b00,
        CMD_URGENT  = 2'b01,
        CMD_RESTART = 2'b10,
        CMD_FINISH  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_END  = 2'd2
    } state_e;

endpackage

// File: rtl/pcdma_next_desc.sv
module pcdma_next_desc #(
    parameter int AW = 16,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [CW-1:0] push_count,
    input  logic          push_irq_en,
    input  logic          take,
    output logic          valid,
    output logic [AW-1:0] q_addr,
    output logic [CW-1:0] q_count,
    output logic          q_irq_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            q_addr   <= '0;
            q_count  <= '0;
            q_irq_en <= 1'b0;
        end else begin
            if (take) begin
                valid <= 1'b0;
            end
            if (push) begin
                valid    <= 1'b1;
                q_addr   <= push_addr;
                q_count  <= push_count;
                q_irq_en <= push_irq_en;
            end
        end
    end

    AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) take |-> valid); // R2

endmodule

// File: rtl/pcdma_walker.sv
module pcdma_walker #(
    parameter int AW = 16,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          ld_irq_en,
    input  logic          step,
    input  logic          rewind,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] words,
    output logic          last,
    output logic          unit_irq_en
);

    logic [AW-1:0] start_addr;
    logic [CW-1:0] start_count;
    logic [CW-1:0] cur_count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_addr  <= '0;
            start_count <= '0;
            cur_addr    <= '0;
            cur_count   <= '0;
            words       <= '0;
            unit_irq_en <= 1'b0;
        end else if (load) begin
            start_addr  <= ld_addr;
            start_count <= ld_count;
            cur_addr    <= ld_addr;
            cur_count   <= ld_count;
            words       <= '0;
            unit_irq_en <= ld_irq_en;
        end else if (rewind) begin
            cur_addr  <= start_addr;
            cur_count <= start_count;
            words     <= '0;
        end else if (step) begin
            cur_addr  <= cur_addr + 1'b1;
            cur_count <= cur_count - 1'b1;
            words     <= words + 1'b1;
        end
    end

    assign last = (cur_count == {{(CW-1){1'b0}}, 1'b1});

    AST_RESTART_REWINDS: assert property (@(posedge clk) disable iff (!rst_n) (rewind && !load) |=> (cur_addr == start_addr) && (words == '0)); // R5
    AST_NO_COUNT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) step |-> (cur_count != '0)); // R9

endmodule

// File: rtl/pcdma_ctrl.sv
module pcdma_ctrl
    import pcdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic [DW-1:0] cmd_data,
    input  logic          nxt_valid,
    input  logic          last,
    input  logic [CW-1:0] words,
    input  logic [AW-1:0] cur_addr,
    input  logic          unit_irq_en,
    output logic          take,
    output logic          step,
    output logic          rewind,
    output logic          ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          urgent,
    output logic          irq,
    output logic [CW-1:0] done_words
);

    state_e state, state_nxt;
    cmd_e   code;
    logic   accept;
    logic   is_req;

    assign code   = cmd_e'(cmd_code);
    assign ready  = (state == S_RUN);
    assign accept = cmd_valid && ready;
    assign is_req = (code == CMD_REQ) || (code == CMD_URGENT);
    assign step   = accept && is_req;
    assign rewind = accept && (code == CMD_RESTART);
    assign take   = ((state == S_IDLE) || (state == S_END)) && nxt_valid;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (nxt_valid) state_nxt = S_RUN;
            S_RUN: begin
                if (accept && (code == CMD_FINISH)) begin
                    state_nxt = S_END;
                end else if (step && last) begin
                    state_nxt = S_END;
                end
            end
            S_END: state_nxt = nxt_valid ? S_RUN : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            urgent     <= 1'b0;
            irq        <= 1'b0;
            done_words <= '0;
        end else begin
            mem_we <= step;
            urgent <= step && (code == CMD_URGENT);
            irq    <= (state == S_END) && unit_irq_en;
            if (step) begin
                mem_addr  <= cur_addr;
                mem_wdata <= cmd_data;
            end
            if (state == S_END) begin
                done_words <= words;
            end
        end
    end

    AST_WRITE_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> $past(cmd_valid && ready && !cmd_code[1])); // R3
    AST_URGENT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) urgent |-> mem_we); // R4
    AST_NO_IRQ_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !$past(cmd_valid && ready && (cmd_code == 2'b10))); // R6
    AST_FINISH_CLOSES_UNIT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && ready && (cmd_code == 2'b11)) |=> !ready); // R7

endmodule

// File: rtl/pcdma_rx_chan.sv
module pcdma_rx_chan #(
    parameter int AW = 16,
    parameter int CW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_push,
    input  logic [AW-1:0] desc_addr,
    input  logic [CW-1:0] desc_count,
    input  logic          desc_irq_en,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic [DW-1:0] cmd_data,
    output logic          cmd_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          urgent,
    output logic          irq,
    output logic [CW-1:0] done_words
);

    logic          nxt_valid;
    logic [AW-1:0] nxt_addr;
    logic [CW-1:0] nxt_count;
    logic          nxt_irq_en;
    logic          take;
    logic          step;
    logic          rewind;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] words;
    logic          last;
    logic          unit_irq_en;

    pcdma_next_desc #(.AW(AW), .CW(CW)) i_next (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (desc_push),
        .push_addr   (desc_addr),
        .push_count  (desc_count),
        .push_irq_en (desc_irq_en),
        .take        (take),
        .valid       (nxt_valid),
        .q_addr      (nxt_addr),
        .q_count     (nxt_count),
        .q_irq_en    (nxt_irq_en)
    );

    pcdma_walker #(.AW(AW), .CW(CW)) i_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (take),
        .ld_addr     (nxt_addr),
        .ld_count    (nxt_count),
        .ld_irq_en   (nxt_irq_en),
        .step        (step),
        .rewind      (rewind),
        .cur_addr    (cur_addr),
        .words       (words),
        .last        (last),
        .unit_irq_en (unit_irq_en)
    );

    pcdma_ctrl #(.AW(AW), .CW(CW), .DW(DW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .cmd_data    (cmd_data),
        .nxt_valid   (nxt_valid),
        .last        (last),
        .words       (words),
        .cur_addr    (cur_addr),
        .unit_irq_en (unit_irq_en),
        .take        (take),
        .step        (step),
        .rewind      (rewind),
        .ready       (cmd_ready),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .urgent      (urgent),
        .irq         (irq),
        .done_words  (done_words)
    );

endmodule

// File: tb/test_pcdma_rx_chan.sv
module test_pcdma_rx_chan;

    localparam int AW = 16;
    localparam int CW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_push = 1'b0;
    logic [AW-1:0] desc_addr = '0;
    logic [CW-1:0] desc_count = '0;
    logic          desc_irq_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_code = 2'b00;
    logic [DW-1:0] cmd_data = '0;
    logic          cmd_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          urgent;
    logic          irq;
    logic [CW-1:0] done_words;

    pcdma_rx_chan #(.AW(AW), .CW(CW), .DW(DW)) i_pcdma_rx_chan (
        .clk(clk), .rst_n(rst_n),
        .desc_push(desc_push), .desc_addr(desc_addr), .desc_count(desc_count), .desc_irq_en(desc_irq_en),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .urgent(urgent), .irq(irq), .done_words(done_words)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    typedef struct { logic [AW-1:0] a; int c; bit ie; } desc_t;
    desc_t dq[$];
    int            m_state = 0;   // 0 idle, 1 run, 2 end
    logic [AW-1:0] m_sa = '0, m_a = '0;
    int            m_sc = 0, m_c = 0, m_w = 0;
    bit            m_ie = 1'b0;
    bit            e_we = 1'b0, e_urg = 1'b0, e_irq = 1'b0;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_data = '0;
    int            e_done = 0;

    task automatic m_load();
        m_sa = dq[0].a; m_a = dq[0].a;
        m_sc = dq[0].c; m_c = dq[0].c;
        m_ie = dq[0].ie; m_w = 0;
        void'(dq.pop_front());
        m_state = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            dq.delete();
            m_state = 0; m_w = 0; e_we = 0; e_urg = 0; e_irq = 0; e_done = 0;
        end else begin
            e_we = 0; e_urg = 0; e_irq = 0;
            case (m_state)
                0: if (dq.size() > 0) m_load();
                1: if (cmd_valid) begin
                    if (cmd_code <= 2'b01) begin
                        e_we = 1; e_addr = m_a; e_data = cmd_data; e_urg = (cmd_code == 2'b01);
                        m_a = m_a + 1'b1; m_c--; m_w++;
                        if (m_c == 0) m_state = 2;
                    end else if (cmd_code == 2'b10) begin
                        m_a = m_sa; m_c = m_sc; m_w = 0;
                    end else begin
                        m_state = 2;
                    end
                end
                default: begin
                    e_done = m_w; e_irq = m_ie;
                    if (dq.size() > 0) m_load(); else m_state = 0;
                end
            endcase
            if (desc_push) begin
                if (dq.size() > 0) dq.delete();
                dq.push_back('{desc_addr, int'(desc_count), desc_irq_en});
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 mem_we", mem_we, e_we);
            if (e_we) begin
                chk("R3 mem_addr", mem_addr, e_addr);
                chk("R3 mem_wdata", mem_wdata, e_data);
            end
            chk("R4 urgent", urgent, e_urg);
            chk("R7 irq", irq, e_irq);
            chk("R8 done_words", done_words, e_done);
            chk("R9 cmd_ready", cmd_ready, m_state == 1);
        end
    end

    task automatic send(input logic [1:0] c, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_code = c; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push(input logic [AW-1:0] a, input int n, input bit ie);
        desc_push = 1'b1; desc_addr = a; desc_count = n[CW-1:0]; desc_irq_en = ie;
        @(negedge clk);
        desc_push = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", cmd_ready, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 urgent", urgent, 0);
        chk("R1 irq", irq, 0);
        chk("R1 done", done_words, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", cmd_ready, 0);

        // R10: commands while idle are ignored
        send(2'b00, 16'hDEAD);
        chk("R10 no write idle", mem_we, 0);
        chk("R10 still idle", cmd_ready, 0);

        // R2: load a maximum-count descriptor
        push(16'h0100, 1023, 1'b1);
        chk("R2 not yet ready", cmd_ready, 0);
        @(negedge clk);
        chk("R2 ready after load", cmd_ready, 1);

        send(2'b00, 16'h1111);
        chk("R3 first write", mem_addr, 16'h0100);
        chk("R3 first data", mem_wdata, 16'h1111);
        send(2'b01, 16'h2222);
        chk("R4 urgent write", urgent, 1);
        chk("R3 address step", mem_addr, 16'h0101);
        send(2'b00, 16'h3333);
        chk("R4 normal not urgent", urgent, 0);

        // R5, R6: restart
        send(2'b10, 16'h0);
        chk("R6 no irq on restart", irq, 0);
        chk("R6 stays ready", cmd_ready, 1);
        @(negedge clk);
        chk("R6 no irq later", irq, 0);
        send(2'b00, 16'h4444);
        chk("R5 rewrite start addr", mem_addr, 16'h0100);
        send(2'b00, 16'h5555);
        chk("R5 second after restart", mem_addr, 16'h0101);

        // R7, R8: finish with a next descriptor pending
        push(16'h0200, 3, 1'b0);
        send(2'b11, 16'h0);
        chk("R7 not ready in end", cmd_ready, 0);
        @(negedge clk);
        chk("R7 irq pulse", irq, 1);
        chk("R8 words after finish", done_words, 2);
        chk("R7 next unit started", cmd_ready, 1);
        @(negedge clk);
        chk("R7 irq single cycle", irq, 0);

        // R9, R11: exhaust count of a unit without interrupt
        send(2'b00, 16'hA0);
        send(2'b01, 16'hA1);
        send(2'b00, 16'hA2);
        chk("R9 last word written", mem_addr, 16'h0202);
        chk("R9 end after last", cmd_ready, 0);
        @(negedge clk);
        chk("R11 no irq", irq, 0);
        chk("R8 words after exhaust", done_words, 3);
        chk("R9 held off", cmd_ready, 0);
        send(2'b00, 16'hBEEF);
        chk("R10 no write when held off", mem_we, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 still held off", cmd_ready, 0);
        end

        // Randomized mix compared against the model on every clock
        void'($urandom(32'd7));
        for (int i = 0; i < 2000; i++) begin
            int r;
            cmd_valid = ($urandom % 10) < 7;
            r = $urandom % 8;
            cmd_code = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
            cmd_data = 16'($urandom);
            desc_push = ($urandom % 6) == 0;
            desc_addr = 16'($urandom);
            desc_count = CW'(1 + ($urandom % 6));
            desc_irq_en = $urandom % 2;
            @(negedge clk);
        end
        cmd_valid = 1'b0; desc_push = 1'b0;
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule